// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block collects peripheral interrupt requests into numbered groups and decides which one, if any, is offered to the processor core. Each maskable group owns one control word that software reads and writes over a simple memory-mapped port. That word holds a priority level, a per-source enable, the latched request bits and a read-only detect view. A separate non-maskable group collects three fixed sources: an external pin, a watchdog overflow and a system error. These bypass every gate and take precedence over all maskable groups.

A small control word holds the global interrupt enable and the current mask level. Among pending, enabled groups the controller picks the lowest level value, with the lowest group index winning a tie. The winner is offered to the core only when the global enable is set and its level is numerically below the mask. When the core signals that it takes the interrupt, the controller pulses an acknowledge for one cycle that carries the winning group and level. In the same step it clears the global enable, so the handler must set it again before a nested interrupt can be offered.

Top module: `irq_group_ctrl`

## Requirements
- R1: The control word sits at byte offset 0x000, with the global enable in bit 3 and the mask level in bits 2:0. Group n's word sits at 0x100 + 4*n for n = 0 and n = 2..19. Offset 0x104 (the missing group 1) and any index above 19 read as zero, and writes there change nothing.
- R2: After reset every group word, the global enable and the mask read zero, and the interrupt line and the acknowledge are low.
- R3: A maskable group word holds the level in bits 14:12 and the source enables in bits 11:8, both written only when the upper byte strobe (strobe bit 1) is set. Bits 7:4 are the requests and bits 3:0 are the detect bits, which read as request AND enable and ignore writes.
- R4: Maskable source bit s of group n is input bit (n-2)*4+s. A rising edge on it sets request bit s. Writing 1 to a request bit with the lower byte strobe (strobe bit 0) clears it. An edge in the same cycle as the clear leaves the bit set.
- R5: A maskable winner raises the interrupt line only while the global enable is 1 and its level is less than the mask. A mask of 0 therefore blocks every maskable group.
- R6: Among groups that have an enabled request, the lowest level value wins, and equal levels go to the lowest group index.
- R7: Non-maskable request bits 2:0 of group 0 (pin, watchdog, system error) are set on rising input edges and cleared by writing 1. Any of them raises the interrupt line regardless of the global enable and the mask, and outranks every maskable group, reporting group 0 and level 0.
- R8: A take input high while the interrupt line is high produces, on the next cycle, an acknowledge pulse carrying the winner's group and level as they stood in the take cycle. A take while the line is low produces no acknowledge.
- R9: An accepted interrupt clears the global enable on the next cycle. The clear wins over a bus write to the enable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe for the register port |
| bus_strb_i | input | 2 | Byte lane strobes; bit 0 is the lower byte |
| bus_addr_i | input | 9 | Byte offset of the access |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i (combinational) |
| nmi_src_i | input | 3 | Non-maskable sources: pin, watchdog, system error |
| grp_src_i | input | 72 | Maskable sources, 4 per group for groups 2..19 |
| irq_o | output | 1 | Interrupt offered to the core |
| take_i | input | 1 | Core takes the offered interrupt |
| ack_o | output | 1 | One-cycle acknowledge of an accepted interrupt |
| ack_grp_o | output | 5 | Group index of the accepted interrupt |
| ack_lvl_o | output | 3 | Level of the accepted interrupt |

## Verification
A corrupted request or enable bit appears in the detect field of the same word at the next read. If that bit reaches arbitration, the interrupt line rises or falls in the very cycle the state goes wrong. A wrong winner choice stays hidden until a take, and then shows in the group and level of the acknowledge one cycle later. An enable flag that fails to clear appears as the interrupt line staying high in the cycle right after the acknowledge, and as bit 3 of the control word at the next read.

// File: rtl/irq_group_pkg.sv
package irq_group_pkg;
  localparam int DW         = 16;  // register port data width
  localparam int LV_LSB     = 12;  // level field of a group word
  localparam int EN_LSB     = 8;   // source enable field
  localparam int RQ_LSB     = 4;   // request field (write 1 to clear)
  localparam int DT_LSB     = 0;   // detect field (read only)
  localparam int CTL_IE_BIT = 3;   // global enable bit in the control word
  localparam int NMI_W      = 3;   // non-maskable sources
  localparam int GRP_OFS    = 2;   // index of the first maskable group
endpackage

// File: rtl/irq_edge_req.sv
module irq_edge_req #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] req_o
);
  logic [W-1:0] src_q, req_q, req_d, rise;

  always_comb begin
    rise  = src_i & ~src_q;
    req_d = (req_q & ~clr_i) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      req_q <= '0;
    end else begin
      src_q <= src_i;
      req_q <= req_d;
    end
  end

  assign req_o = req_q;

  // an edge always lands, even against a same-cycle clear
  assert_edge_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i & ~src_q) != '0 |=> (req_q & $past(src_i & ~src_q)) == $past(src_i & ~src_q));
endmodule

// File: rtl/irq_grp_slot.sv
module irq_grp_slot #(
  parameter int SRC_W = 4,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src_i,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic [LVL_W-1:0] lvl_wd_i,
  input  logic [SRC_W-1:0] en_wd_i,
  input  logic [SRC_W-1:0] clr_wd_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic [SRC_W-1:0] en_o,
  output logic [SRC_W-1:0] req_o,
  output logic             pend_o
);
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [SRC_W-1:0] en_q, en_d, clr;

  always_comb begin
    lvl_d = wr_hi_i ? lvl_wd_i : lvl_q;
    en_d  = wr_hi_i ? en_wd_i  : en_q;
    clr   = wr_lo_i ? clr_wd_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      en_q  <= '0;
    end else begin
      lvl_q <= lvl_d;
      en_q  <= en_d;
    end
  end

  irq_edge_req #(.W(SRC_W)) u_req (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .clr_i(clr), .req_o(req_o)
  );

  assign lvl_o  = lvl_q;
  assign en_o   = en_q;
  assign pend_o = |(req_o & en_q);
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb #(
  parameter int N     = 18,
  parameter int LVL_W = 3,
  localparam int SW   = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       pend_i,
  input  logic [N*LVL_W-1:0] lvl_i,
  output logic               any_o,
  output logic [SW-1:0]      best_o,
  output logic [LVL_W-1:0]   lvl_o
);
  always_comb begin
    any_o  = 1'b0;
    best_o = '0;
    lvl_o  = '1;
    for (int i = 0; i < N; i++) begin
      // strict compare keeps the earlier (lower) index on a tie
      if (pend_i[i] && (!any_o || lvl_i[i*LVL_W +: LVL_W] < lvl_o)) begin
        any_o  = 1'b1;
        best_o = SW'(i);
        lvl_o  = lvl_i[i*LVL_W +: LVL_W];
      end
    end
  end

  assert_winner_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> pend_i[best_o]);
  assert_none_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i == '0) |-> !any_o);
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
  import irq_group_pkg::*;
#(
  parameter int NUM_IDX = 20,
  parameter int SRC_W   = 4,
  parameter int LVL_W   = 3,
  parameter int ADDR_W  = 9,
  localparam int NUM_MASK = NUM_IDX - GRP_OFS,
  localparam int IDX_W    = $clog2(NUM_IDX)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_wr_i,
  input  logic [1:0]                bus_strb_i,
  input  logic [ADDR_W-1:0]         bus_addr_i,
  input  logic [DW-1:0]             bus_wdata_i,
  output logic [DW-1:0]             bus_rdata_o,
  input  logic [NMI_W-1:0]          nmi_src_i,
  input  logic [NUM_MASK*SRC_W-1:0] grp_src_i,
  output logic                      irq_o,
  input  logic                      take_i,
  output logic                      ack_o,
  output logic [IDX_W-1:0]          ack_grp_o,
  output logic [LVL_W-1:0]          ack_lvl_o
);
  localparam int REG_AW = ADDR_W - 3;
  localparam int SW     = $clog2(NUM_MASK);

  // reset: asserted asynchronously, released on the clock
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_s, rst_m} <= 2'b00;
    else        {rst_s, rst_m} <= {rst_m, 1'b1};
  end

  // address decode
  logic              grp_region, wr_lo, wr_hi, ctl_sel, nmi_sel;
  logic [REG_AW-1:0] widx;
  logic [NUM_MASK-1:0] slot_sel;
  logic unused_bits;

  assign grp_region  = bus_addr_i[ADDR_W-1];
  assign widx        = bus_addr_i[ADDR_W-2:2];
  assign ctl_sel     = !grp_region && (widx == '0);
  assign nmi_sel     = grp_region && (widx == '0);
  assign wr_lo       = bus_wr_i & bus_strb_i[0];
  assign wr_hi       = bus_wr_i & bus_strb_i[1];
  assign unused_bits = ^{bus_wdata_i[DW-1], bus_addr_i[1:0]};

  // maskable groups
  logic [NUM_MASK-1:0]       pend;
  logic [NUM_MASK*LVL_W-1:0] lvl_flat;
  logic [NUM_MASK-1:0][DW-1:0] slot_rd;

  for (genvar k = 0; k < NUM_MASK; k++) begin : g_slot
    logic [LVL_W-1:0] lvl;
    logic [SRC_W-1:0] en, req;

    assign slot_sel[k] = grp_region && (widx == REG_AW'(k + GRP_OFS));

    irq_grp_slot #(.SRC_W(SRC_W), .LVL_W(LVL_W)) u_slot (
      .clk(clk), .rst_n(rst_s),
      .src_i(grp_src_i[k*SRC_W +: SRC_W]),
      .wr_hi_i(wr_hi & slot_sel[k]),
      .wr_lo_i(wr_lo & slot_sel[k]),
      .lvl_wd_i(bus_wdata_i[LV_LSB +: LVL_W]),
      .en_wd_i(bus_wdata_i[EN_LSB +: SRC_W]),
      .clr_wd_i(bus_wdata_i[RQ_LSB +: SRC_W]),
      .lvl_o(lvl), .en_o(en), .req_o(req), .pend_o(pend[k])
    );

    assign lvl_flat[k*LVL_W +: LVL_W] = lvl;
    assign slot_rd[k] = (DW'(lvl) << LV_LSB) | (DW'(en) << EN_LSB)
                      | (DW'(req) << RQ_LSB) | (DW'(req & en) << DT_LSB);
  end

  // non-maskable group
  logic [NMI_W-1:0] nmi_req;
  logic             nmi_pend;

  irq_edge_req #(.W(NMI_W)) u_nmi (
    .clk(clk), .rst_n(rst_s), .src_i(nmi_src_i),
    .clr_i((wr_lo & nmi_sel) ? bus_wdata_i[NMI_W-1:0] : '0),
    .req_o(nmi_req)
  );
  assign nmi_pend = |nmi_req;

  // arbitration and mask gate
  logic             any;
  logic [SW-1:0]    best_slot;
  logic [LVL_W-1:0] best_lvl;

  irq_level_arb #(.N(NUM_MASK), .LVL_W(LVL_W)) u_arb (
    .clk(clk), .rst_n(rst_s), .pend_i(pend), .lvl_i(lvl_flat),
    .any_o(any), .best_o(best_slot), .lvl_o(best_lvl)
  );

  logic             ie_q, ie_d, accept, ack_d;
  logic [LVL_W-1:0] mask_q, mask_d, win_lvl, lvl_d;
  logic [IDX_W-1:0] win_grp, grp_d;

  assign win_grp = nmi_pend ? '0 : IDX_W'(best_slot) + IDX_W'(GRP_OFS);
  assign win_lvl = nmi_pend ? '0 : best_lvl;
  assign irq_o   = nmi_pend || (ie_q && any && (best_lvl < mask_q));
  assign accept  = take_i && irq_o;

  always_comb begin
    ie_d   = ie_q;
    mask_d = mask_q;
    if (ctl_sel && wr_lo) begin
      ie_d   = bus_wdata_i[CTL_IE_BIT];
      mask_d = bus_wdata_i[LVL_W-1:0];
    end
    if (accept) ie_d = 1'b0;
    ack_d = accept;
    grp_d = accept ? win_grp : '0;
    lvl_d = accept ? win_lvl : '0;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ie_q      <= 1'b0;
      mask_q    <= '0;
      ack_o     <= 1'b0;
      ack_grp_o <= '0;
      ack_lvl_o <= '0;
    end else begin
      ie_q      <= ie_d;
      mask_q    <= mask_d;
      ack_o     <= ack_d;
      ack_grp_o <= grp_d;
      ack_lvl_o <= lvl_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata_o = '0;
    if (ctl_sel) bus_rdata_o = (DW'(ie_q) << CTL_IE_BIT) | DW'(mask_q);
    if (nmi_sel) bus_rdata_o = DW'(nmi_req);
    for (int k = 0; k < NUM_MASK; k++)
      if (slot_sel[k]) bus_rdata_o = slot_rd[k];
  end

  assert_mask_zero_blocks_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (mask_q == '0 && !nmi_pend) |-> !irq_o);
  assert_ie_gates_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (!ie_q && !nmi_pend) |-> !irq_o);
  assert_nmi_bypass_R7: assert property (@(posedge clk) disable iff (!rst_s)
    nmi_pend |-> irq_o);
  assert_nmi_wins_R7: assert property (@(posedge clk) disable iff (!rst_s)
    (take_i && nmi_pend) |=> (ack_o && ack_grp_o == '0 && ack_lvl_o == '0));
  assert_ack_on_take_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (take_i && irq_o) |=> ack_o);
  assert_no_ack_idle_R8: assert property (@(posedge clk) disable iff (!rst_s)
    !(take_i && irq_o) |=> !ack_o);
  assert_ie_cleared_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (take_i && irq_o) |=> !ie_q);
endmodule

// File: tb/irq_group_ctrl_test.sv
module irq_group_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NIDX = 20;
  localparam int NM   = NIDX - 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_strb = 2'b00;
  logic [8:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [2:0]  nmi_src = '0;
  logic [NM*4-1:0] gsrc = '0;
  logic        irq, take = 1'b0, ack;
  logic [4:0]  ack_grp;
  logic [2:0]  ack_lvl;

  int n_chk = 0, n_fail = 0;
  int lv [NIDX], en [NIDX], rq [NIDX];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_group_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_strb_i(bus_strb),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .nmi_src_i(nmi_src), .grp_src_i(gsrc), .irq_o(irq), .take_i(take),
    .ack_o(ack), .ack_grp_o(ack_grp), .ack_lvl_o(ack_lvl)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(int addr, int data, logic [1:0] strb);
    bus_addr = addr[8:0]; bus_wdata = data[15:0]; bus_strb = strb; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0; bus_strb = 2'b00;
  endtask

  task automatic rd(string tag, int addr, int exp);
    bus_addr = addr[8:0];
    #1;
    chk(tag, int'(bus_rdata), exp);
  endtask

  function automatic int gaddr(int n);
    return 32'h100 + 4 * n;
  endfunction

  function automatic int gword(int n);
    return (lv[n] << 12) | (en[n] << 8) | (rq[n] << 4) | (rq[n] & en[n]);
  endfunction

  task automatic pulse_grp(int n, int s);
    gsrc[(n-2)*4 + s] = 1'b1;
    tick();
    gsrc[(n-2)*4 + s] = 1'b0;
    rq[n] |= (1 << s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NIDX; i++) begin lv[i] = 0; en[i] = 0; rq[i] = 0; end
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R2: reset state
    chk("R2 irq", int'(irq), 0);
    chk("R2 ack", int'(ack), 0);
    rd("R2 ctrl", 0, 0);
    for (int n = 0; n < NIDX; n++) rd("R2 group word", gaddr(n), 0);

    // R1: gap and out-of-range slots
    wr(gaddr(1), 16'hFFFF, 2'b11);
    wr(gaddr(20), 16'hFFFF, 2'b11);
    rd("R1 gap reads zero", gaddr(1), 0);
    rd("R1 out of range", gaddr(20), 0);
    rd("R1 nmi untouched", gaddr(0), 0);
    for (int n = 2; n < NIDX; n++) rd("R1 no alias", gaddr(n), 0);

    // R3: field layout and byte lanes
    for (int n = 2; n < NIDX; n++) begin
      lv[n] = n % 8; en[n] = (n * 3) & 15;
      wr(gaddr(n), (lv[n] << 12) | (en[n] << 8), 2'b10);
      wr(gaddr(n), 16'h7F0F, 2'b01);   // lower lane only: level, enable untouched
      wr(gaddr(n), 16'h0000, 2'b00);   // no lanes
      rd("R3 word layout", gaddr(n), gword(n));
    end

    // R4: edge set, write-1 clear, detect = request & enable
    for (int n = 2; n < NIDX; n++) begin
      en[n] = 4'hA;
      wr(gaddr(n), (lv[n] << 12) | (en[n] << 8), 2'b10);
      for (int s = 0; s < 4; s++) begin
        pulse_grp(n, s);
        rd("R4 edge sets request", gaddr(n), gword(n));
        wr(gaddr(n), 1 << (4 + s), 2'b01);
        rq[n] = 0;
        rd("R4 write one clears", gaddr(n), gword(n));
      end
    end
    // R4: edge beats clear in the same cycle
    gsrc[(5-2)*4 + 2] = 1'b1;
    wr(gaddr(5), 1 << 6, 2'b01);
    gsrc[(5-2)*4 + 2] = 1'b0;
    rq[5] = 4;
    rd("R4 set wins over clear", gaddr(5), gword(5));
    wr(gaddr(5), 1 << 6, 2'b01);
    rq[5] = 0;

    // R5: mask sweep on group 7
    en[7] = 4'hF;
    pulse_grp(7, 0);
    for (int l = 0; l < 8; l++) begin
      lv[7] = l;
      wr(gaddr(7), (l << 12) | (15 << 8), 2'b10);
      for (int m = 0; m < 8; m++) begin
        wr(0, 8 | m, 2'b01);
        chk("R5 level below mask", int'(irq), (l < m) ? 1 : 0);
      end
      wr(0, 7, 2'b01);
      chk("R5 enable off blocks", int'(irq), 0);
    end
    wr(gaddr(7), 1 << 4, 2'b01);
    rq[7] = 0;

    // R6, R8, R9: drain all groups in priority order
    for (int n = 2; n < NIDX; n++) begin
      lv[n] = (n * 5) % 7; en[n] = 4'hF;
      wr(gaddr(n), (lv[n] << 12) | (15 << 8), 2'b10);
      gsrc[(n-2)*4 + (n % 4)] = 1'b1;
      rq[n] = 1 << (n % 4);
    end
    tick();
    gsrc = '0;
    for (int round = 0; round < NM; round++) begin
      int bn, bl;
      bn = -1; bl = 8;
      for (int n = 2; n < NIDX; n++)
        if ((rq[n] & en[n]) != 0 && lv[n] < bl) begin bn = n; bl = lv[n]; end
      wr(0, 8 | 7, 2'b01);
      chk("R5 offered", int'(irq), 1);
      take = 1'b1;
      tick();
      chk("R8 ack pulse", int'(ack), 1);
      chk("R6 winner group", int'(ack_grp), bn);
      chk("R6 winner level", int'(ack_lvl), bl);
      chk("R9 line drops after accept", int'(irq), 0);
      take = 1'b0;
      tick();
      chk("R8 ack one cycle", int'(ack), 0);
      rd("R9 enable cleared", 0, 7);
      wr(gaddr(bn), rq[bn] << 4, 2'b01);
      rq[bn] = 0;
    end

    // R7: non-maskable group beats everything
    lv[19] = 0; en[19] = 4'hF;
    wr(gaddr(19), 15 << 8, 2'b10);
    pulse_grp(19, 0);
    for (int b = 0; b < 3; b++) begin
      wr(0, 0, 2'b01);
      chk("R7 idle before nmi", int'(irq), 0);
      nmi_src[b] = 1'b1;
      tick();
      nmi_src[b] = 1'b0;
      chk("R7 nmi ignores enable and mask", int'(irq), 1);
      rd("R7 nmi request bit", gaddr(0), 1 << b);
      wr(0, 8 | 7, 2'b01);
      take = 1'b1;
      tick();
      chk("R7 nmi ack", int'(ack), 1);
      chk("R7 nmi group", int'(ack_grp), 0);
      chk("R7 nmi level", int'(ack_lvl), 0);
      take = 1'b0;
      tick();
      wr(gaddr(0), 1 << b, 2'b01);
      rd("R7 nmi cleared", gaddr(0), 0);
      chk("R9 line low after nmi accept", int'(irq), 0);
    end
    wr(0, 8 | 7, 2'b01);
    take = 1'b1;
    tick();
    chk("R6 maskable resumes", int'(ack_grp), 19);
    take = 1'b0;
    tick();

    // R8: take with the line low
    wr(0, 0, 2'b01);
    take = 1'b1;
    tick();
    chk("R8 no ack when idle", int'(ack), 0);
    take = 1'b0;

    // R9: accept beats a same-cycle enable write
    wr(0, 8 | 7, 2'b01);
    chk("R9 offered", int'(irq), 1);
    take = 1'b1;
    wr(0, 8 | 7, 2'b01);
    take = 1'b0;
    chk("R9 ack on race", int'(ack), 1);
    rd("R9 clear wins", 0, 7);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule